// File: doc/BRIEF.md
# Banked Framebuffer Window Address Translator

This block sits between a CPU byte-access port and the video memory of a display adapter. Each access cycle goes down one of three paths. An address at or above a programmable linear base is passed straight through, with the base subtracted. An address below the linear base and below 0xB0000 goes through the legacy 64 KB window. There the low 16 address bits are added to a bank number scaled by the selected granularity: 64 KB by default, or 32 KB. Any other address falls into a hole and is dropped.

Translation is combinational. The video memory is a byte array inside the block. It stores writes on the clock edge and returns read data one cycle after the read strobe. Any access whose computed offset lies beyond the memory size is dropped. In that case a read returns zero and a write changes nothing. The block also presents a plane offset for legacy planar logic. This is the bank number shifted left by the granularity.

Top module: `fbwin_xlate`

## Requirements
- R1: When `cpu_addr` >= `lfb_base`, `vm_offset` equals `cpu_addr - lfb_base`, whatever the bank and granularity inputs are.
- R2: When `cpu_addr` < `lfb_base`, `cpu_addr` < 0xB0000 and `gran_32k` = 0, `vm_offset` equals `bank_sel * 65536 + cpu_addr[15:0]`. This also applies to addresses below 0xA0000.
- R3: When `gran_32k` = 1, a windowed access maps to `bank_sel * 32768 + cpu_addr[15:0]`. The window stays 64 KB wide, so bank n+1 overlaps the upper half of bank n.
- R4: An access with 0xB0000 <= `cpu_addr` < `lfb_base` keeps `vm_access` low. A read returns 0 and a write leaves the memory unchanged.
- R5: An access whose offset is >= the memory size (2^`MEM_AW` bytes) keeps `vm_access` low. A read returns 0 and a write leaves the memory unchanged.
- R6: `plane_offset` equals `bank_sel << 16` when `gran_32k` = 0, and `bank_sel << 15` when `gran_32k` = 1.
- R7: `cpu_rdata` is 0 after reset. It loads on the clock edge that ends a cycle with `cpu_rd` high: the addressed byte, or 0 if `vm_access` is low. It holds its value while `cpu_rd` is low.
- R8: `vm_access` is high in the same cycle exactly when `cpu_rd` or `cpu_wr` is high and the address maps to an in-range offset through the LFB or the window path.
- R9: A write with `vm_access` high stores `cpu_wdata` at `vm_offset` on the clock edge. A later read of the same offset through either path, or through any bank alias, returns that byte. A read and a write in the same cycle return the old byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_addr | input | 32 | CPU byte address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| bank_sel | input | 9 | Bank number |
| gran_32k | input | 1 | 1 selects 32 KB bank granularity, 0 selects 64 KB |
| lfb_base | input | 32 | Linear framebuffer base address |
| vm_offset | output | 32 | Translated video-memory offset |
| vm_access | output | 1 | Access reaches memory this cycle |
| plane_offset | output | 25 | Bank base for legacy planar logic |
| cpu_rdata | output | 8 | Read data, valid the cycle after `cpu_rd` |

## Verification
A wrong path decision or offset shows up in the same cycle on `vm_offset` and `vm_access`. The bench samples these in every cycle of its vector walk.

A hole access or an oversize offset that wrongly reaches memory leaves no immediate trace on `vm_offset`. Instead it corrupts a byte. The bench places a known byte where the stray write would alias and reads it back a few cycles later, so the corruption appears as a wrong `cpu_rdata` one cycle after that read.

A missing zero on a dropped read appears on `cpu_rdata` on the very next cycle. The bench ensures the previous value was nonzero before such a read.

// File: rtl/fbwin_pkg.sv
package fbwin_pkg;

  localparam int ADDR_W = 32;
  typedef logic [ADDR_W-1:0] addr_t;

  // Which route an address takes through the translator.
  typedef enum logic [1:0] {
    PATH_LFB  = 2'd0,
    PATH_BANK = 2'd1,
    PATH_HOLE = 2'd2
  } path_e;

  // Linear path: distance above the programmed base.
  function automatic addr_t lfb_offset(addr_t a, addr_t base);
    return a - base;
  endfunction

  // Window path: scaled bank plus the full 16-bit window offset.
  function automatic addr_t bank_offset(addr_t bank_ext, logic [15:0] lo, logic g32);
    addr_t scaled;
    scaled = g32 ? (bank_ext << 15) : (bank_ext << 16);
    return scaled + addr_t'(lo);
  endfunction

  // Bank base handed to planar logic.
  function automatic addr_t plane_base(addr_t bank_ext, logic g32);
    return g32 ? (bank_ext << 15) : (bank_ext << 16);
  endfunction

endpackage

// File: rtl/fbwin_decode.sv
module fbwin_decode
  import fbwin_pkg::*;
#(
  parameter int    BANK_W  = 9,
  parameter addr_t WIN_END = 32'h000B_0000,
  localparam int   PLANE_W = BANK_W + 16
) (
  input  addr_t              addr,
  input  addr_t              base,
  input  logic [BANK_W-1:0]  bank,
  input  logic               g32,
  output path_e              path,
  output addr_t              offset,
  output logic [PLANE_W-1:0] plane
);

  addr_t bank_ext;
  addr_t plane_full;

  assign bank_ext = addr_t'(bank);

  always_comb begin
    if (addr >= base) begin
      path   = PATH_LFB;
      offset = lfb_offset(addr, base);
    end else if (addr < WIN_END) begin
      path   = PATH_BANK;
      offset = bank_offset(bank_ext, addr[15:0], g32);
    end else begin
      path   = PATH_HOLE;
      offset = bank_offset(bank_ext, addr[15:0], g32);
    end
  end

  assign plane_full = plane_base(bank_ext, g32);
  assign plane      = plane_full[PLANE_W-1:0];

endmodule

// File: rtl/fbwin_gate.sv
module fbwin_gate
  import fbwin_pkg::*;
#(
  parameter int MEM_AW = 11
) (
  input  path_e offset_path,
  input  addr_t offset,
  input  logic  rd,
  input  logic  wr,
  output logic  in_mem,
  output logic  access
);

  localparam logic [ADDR_W:0] MEM_LIMIT = (ADDR_W+1)'(1) << MEM_AW;

  logic target_ok;

  assign in_mem    = {1'b0, offset} < MEM_LIMIT;
  assign target_ok = (offset_path == PATH_LFB) || (offset_path == PATH_BANK);
  assign access    = (rd || wr) && target_ok && in_mem;

endmodule

// File: rtl/fbwin_vram.sv
module fbwin_vram #(
  parameter int MEM_AW = 11,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << MEM_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic              wr,
  input  logic              access,
  input  logic [MEM_AW-1:0] idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr && access) mem[idx] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd) begin
      rdata <= access ? mem[idx] : '0;
    end
  end

endmodule

// File: rtl/fbwin_xlate.sv
module fbwin_xlate
  import fbwin_pkg::*;
#(
  parameter int    MEM_AW  = 11,
  parameter int    DATA_W  = 8,
  parameter int    BANK_W  = 9,
  parameter addr_t WIN_END = 32'h000B_0000,
  localparam int   PLANE_W = BANK_W + 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [31:0]        cpu_addr,
  input  logic               cpu_rd,
  input  logic               cpu_wr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  input  logic [BANK_W-1:0]  bank_sel,
  input  logic               gran_32k,
  input  logic [31:0]        lfb_base,
  output logic [31:0]        vm_offset,
  output logic               vm_access,
  output logic [PLANE_W-1:0] plane_offset,
  output logic [DATA_W-1:0]  cpu_rdata
);

  path_e path;
  logic  path_is_lfb;
  logic  path_is_bank;
  logic  path_is_hole;
  logic  off_in_mem;

  fbwin_decode #(.BANK_W(BANK_W), .WIN_END(WIN_END)) u_decode (
    .addr   (cpu_addr),
    .base   (lfb_base),
    .bank   (bank_sel),
    .g32    (gran_32k),
    .path   (path),
    .offset (vm_offset),
    .plane  (plane_offset)
  );

  assign path_is_lfb  = (path == PATH_LFB);
  assign path_is_bank = (path == PATH_BANK);
  assign path_is_hole = (path == PATH_HOLE);

  fbwin_gate #(.MEM_AW(MEM_AW)) u_gate (
    .offset_path (path),
    .offset      (vm_offset),
    .rd          (cpu_rd),
    .wr          (cpu_wr),
    .in_mem      (off_in_mem),
    .access      (vm_access)
  );

  fbwin_vram #(.MEM_AW(MEM_AW), .DATA_W(DATA_W)) u_vram (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd     (cpu_rd),
    .wr     (cpu_wr),
    .access (vm_access),
    .idx    (vm_offset[MEM_AW-1:0]),
    .wdata  (cpu_wdata),
    .rdata  (cpu_rdata)
  );

endmodule

// File: rtl/fbwin_chk.sv
module fbwin_chk #(
  parameter int          MEM_AW  = 11,
  parameter int          DATA_W  = 8,
  parameter int          BANK_W  = 9,
  parameter logic [31:0] WIN_END = 32'h000B_0000,
  localparam int         PLANE_W = BANK_W + 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [31:0]        cpu_addr,
  input logic               cpu_rd,
  input logic               cpu_wr,
  input logic               gran_32k,
  input logic [31:0]        lfb_base,
  input logic [31:0]        vm_offset,
  input logic               vm_access,
  input logic [PLANE_W-1:0] plane_offset,
  input logic [DATA_W-1:0]  cpu_rdata,
  input logic               path_is_lfb,
  input logic               path_is_bank,
  input logic               path_is_hole,
  input logic               off_in_mem
);

  localparam logic [32:0] LIMIT = 33'(1) << MEM_AW;

  logic        strobe;
  logic [31:0] lin_dist;

  assign strobe   = cpu_rd || cpu_wr;
  assign lin_dist = cpu_addr - lfb_base;

  p_lfb_reach_r1: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && cpu_addr >= lfb_base && {1'b0, lin_dist} < LIMIT |-> vm_access);

  p_win64_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    path_is_bank && !gran_32k |-> vm_offset[15:0] == cpu_addr[15:0]);

  p_win32_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    path_is_bank && gran_32k |-> vm_offset[14:0] == cpu_addr[14:0]);

  p_hole_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr < lfb_base && cpu_addr >= WIN_END |-> !vm_access);

  p_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vm_access |-> {1'b0, vm_offset} < LIMIT && off_in_mem);

  p_plane_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gran_32k ? (plane_offset[14:0] == 15'd0) : (plane_offset[15:0] == 16'd0));

  p_drop_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && !vm_access |=> cpu_rdata == '0);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd |=> $stable(cpu_rdata));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |-> !vm_access);

  p_one_path_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({path_is_lfb, path_is_bank, path_is_hole}) == 1);

endmodule

bind fbwin_xlate fbwin_chk #(
  .MEM_AW(MEM_AW), .DATA_W(DATA_W), .BANK_W(BANK_W), .WIN_END(WIN_END)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_addr     (cpu_addr),
  .cpu_rd       (cpu_rd),
  .cpu_wr       (cpu_wr),
  .gran_32k     (gran_32k),
  .lfb_base     (lfb_base),
  .vm_offset    (vm_offset),
  .vm_access    (vm_access),
  .plane_offset (plane_offset),
  .cpu_rdata    (cpu_rdata),
  .path_is_lfb  (path_is_lfb),
  .path_is_bank (path_is_bank),
  .path_is_hole (path_is_hole),
  .off_in_mem   (off_in_mem)
);

// File: tb/tb_fbwin_xlate.sv
module tb_fbwin_xlate;

  localparam int MEM_AW = 17;                 // 128 KB memory for the bench
  localparam logic [31:0] BASE = 32'hE000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [8:0]  bank_sel = '0;
  logic        gran_32k = 1'b0;
  logic [31:0] lfb_base = BASE;
  logic [31:0] vm_offset;
  logic        vm_access;
  logic [24:0] plane_offset;
  logic [7:0]  cpu_rdata;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fbwin_xlate #(.MEM_AW(MEM_AW)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .bank_sel(bank_sel),
    .gran_32k(gran_32k), .lfb_base(lfb_base), .vm_offset(vm_offset),
    .vm_access(vm_access), .plane_offset(plane_offset), .cpu_rdata(cpu_rdata)
  );

  typedef struct packed {
    logic [1:0]  op;      // 0 idle, 1 read, 2 write
    logic [31:0] addr;
    logic [8:0]  bank;
    logic        g32;
    logic        chk_off;
    logic [31:0] exp_off;
    logic        exp_acc;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{2'd2, 32'hE000_0010, 9'd0, 1'b0, 1'b1, 32'h0000_0010, 1'b1}, // R1
    '{2'd1, 32'hE001_FFFF, 9'd7, 1'b1, 1'b1, 32'h0001_FFFF, 1'b1}, // R1 top byte
    '{2'd1, 32'hE002_0000, 9'd0, 1'b0, 1'b1, 32'h0002_0000, 1'b0}, // R5
    '{2'd2, 32'h000A_1234, 9'd1, 1'b0, 1'b1, 32'h0001_1234, 1'b1}, // R2
    '{2'd2, 32'h000A_1234, 9'd1, 1'b1, 1'b1, 32'h0000_9234, 1'b1}, // R3
    '{2'd1, 32'h000A_FFFF, 9'd3, 1'b1, 1'b1, 32'h0002_7FFF, 1'b0}, // R5 via 32K
    '{2'd1, 32'h000A_FFFF, 9'd2, 1'b1, 1'b1, 32'h0001_FFFF, 1'b1}, // R3
    '{2'd2, 32'h000B_0000, 9'd0, 1'b0, 1'b0, 32'h0,         1'b0}, // R4
    '{2'd1, 32'h000B_FFFF, 9'd0, 1'b0, 1'b0, 32'h0,         1'b0}, // R4
    '{2'd1, 32'h0000_1234, 9'd0, 1'b0, 1'b1, 32'h0000_1234, 1'b1}, // R2 below window
    '{2'd0, 32'h000A_0000, 9'd0, 1'b0, 1'b1, 32'h0,         1'b0}, // R8 idle
    '{2'd2, 32'h000A_0000, 9'd2, 1'b0, 1'b1, 32'h0002_0000, 1'b0}  // R5 via 64K
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one access at a falling edge, let it take effect on the rising edge.
  task automatic access(logic rd, logic wr, logic [31:0] a, logic [8:0] b,
                        logic g, logic [7:0] d);
    @(negedge clk);
    cpu_rd = rd; cpu_wr = wr; cpu_addr = a; bank_sel = b; gran_32k = g; cpu_wdata = d;
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
  endtask

  // Read and compare the byte visible one cycle after the strobe.
  task automatic read_chk(string req, logic [31:0] a, logic [8:0] b, logic g,
                          logic [7:0] exp);
    access(1'b1, 1'b0, a, b, g, 8'h00);
    check(req, {24'h0, cpu_rdata}, {24'h0, exp});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset rdata", {24'h0, cpu_rdata}, 32'h0);
    check("R8 reset idle access", {31'h0, vm_access}, 32'h0);
    rst_n = 1'b1;

    // Vector walk: translation and access decision sampled mid-cycle.
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cpu_rd = (VEC[i].op == 2'd1); cpu_wr = (VEC[i].op == 2'd2);
      cpu_addr = VEC[i].addr; bank_sel = VEC[i].bank; gran_32k = VEC[i].g32;
      cpu_wdata = 8'(i + 1);
      #1;
      if (VEC[i].chk_off) check($sformatf("R1/R2/R3 offset vec %0d", i), vm_offset, VEC[i].exp_off);
      check($sformatf("R8 access vec %0d", i), {31'h0, vm_access}, {31'h0, VEC[i].exp_acc});
    end
    @(negedge clk); cpu_rd = 1'b0; cpu_wr = 1'b0;

    // R6 plane offset
    @(negedge clk); bank_sel = 9'd5; gran_32k = 1'b0; #1;
    check("R6 plane 64K", {7'h0, plane_offset}, 32'h0005_0000);
    gran_32k = 1'b1; #1;
    check("R6 plane 32K", {7'h0, plane_offset}, 32'h0002_8000);
    bank_sel = 9'h1FF; gran_32k = 1'b0; #1;
    check("R6 plane max bank", {7'h0, plane_offset}, 32'h01FF_0000);

    // R9 store via linear path, fetch via window
    access(1'b0, 1'b1, BASE + 32'h40, 9'd0, 1'b0, 8'hA5);
    read_chk("R9 lfb->window", 32'h000A_0040, 9'd0, 1'b0, 8'hA5);
    // R9 store via 32K window, fetch via linear
    access(1'b0, 1'b1, 32'h000A_0100, 9'd3, 1'b1, 8'h3C);
    read_chk("R9 window32->lfb", BASE + 32'h0001_8100, 9'd0, 1'b0, 8'h3C);
    // R3 alias: 32K bank1 at 0x8100 equals 64K bank1 at 0x0100
    access(1'b0, 1'b1, 32'h000A_8100, 9'd1, 1'b1, 8'h5A);
    read_chk("R3 bank alias", 32'h000A_0100, 9'd1, 1'b0, 8'h5A);

    // R7 hold across idle cycles
    repeat (3) @(negedge clk);
    check("R7 hold", {24'h0, cpu_rdata}, 32'h5A);

    // R4 hole write must not alias onto offset 0x40
    access(1'b0, 1'b1, 32'h000B_0040, 9'd0, 1'b0, 8'h77);
    read_chk("R4 hole write dropped", BASE + 32'h40, 9'd0, 1'b0, 8'hA5);
    read_chk("R4 hole read zero", 32'h000B_0040, 9'd0, 1'b0, 8'h00);

    // R5 oversize write must not wrap onto offset 0x40
    read_chk("R9 reload", BASE + 32'h40, 9'd0, 1'b0, 8'hA5);
    access(1'b0, 1'b1, BASE + 32'h0002_0040, 9'd0, 1'b0, 8'h99);
    access(1'b0, 1'b1, 32'h000A_0040, 9'd2, 1'b0, 8'h98);
    read_chk("R5 oversize write dropped", BASE + 32'h40, 9'd0, 1'b0, 8'hA5);
    read_chk("R5 oversize read zero", BASE + 32'h0002_0040, 9'd0, 1'b0, 8'h00);

    // R9 read and write together return the old byte
    read_chk("R9 reload 2", BASE + 32'h40, 9'd0, 1'b0, 8'hA5);
    access(1'b1, 1'b1, BASE + 32'h40, 9'd0, 1'b0, 8'h11);
    check("R9 read-during-write old", {24'h0, cpu_rdata}, 32'hA5);
    read_chk("R9 write landed", BASE + 32'h40, 9'd0, 1'b0, 8'h11);

    // R1 with base lowered into the window range
    @(negedge clk); lfb_base = 32'h000A_8000; cpu_rd = 1'b1;
    cpu_addr = 32'h000A_9000; bank_sel = 9'd1; gran_32k = 1'b0; #1;
    check("R1 low base offset", vm_offset, 32'h0000_1000);
    @(negedge clk); cpu_rd = 1'b0; lfb_base = BASE;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule